// File: doc/BRIEF.md
# Peripheral Interrupt Flag and Vector Unit

This unit sits beside the CPU of a small 8-bit controller. It holds the event flags of a timer and of a serial port, together with their enable bits. It combines these into a single interrupt request and reports the pair of memory addresses from which the CPU fetches the handler address for the winning source.

The timer and serial datapaths signal events with one-cycle set pulses. The unit latches each pulse into a flag. Software reads the flags and writes the enables through a small register port. Some flags share one enable bit, and some share one vector. A nonmaskable wake-up request from a sleeping bus controller takes precedence over everything else.

A flag is not cleared by writing to it. Software clears it in two steps: it reads the status register while the flag is set, which arms the flag. Any later access of the matching data register then clears the flag, provided it is still armed. A new set event between the two steps disarms the flag, so an event that arrives during the sequence cannot be lost.

Top module: `periph_irq_vector`

## Requirements
- R1: After reset, every flag, every arm and every enable bit is zero. With `wake_req` low, `irq` is 0 and both vector outputs are 16'h0000.
- R2: A set pulse on `tmr_set[i]` or `ser_set[i]` sets that flag at the next rising edge. Reading address 0 (timer status) returns `tmr_set` order {cap_a, cap_b, cmp_a, cmp_b, ovf} in bits 7..3. Reading address 2 (serial status) returns {tx_empty, tx_done, rx_over, rx_full, line_idle} in bits 7..3. Bits 2..0 read as zero.
- R3: Address 1 (timer enables) holds the capture enable in bit 7, the compare enable in bit 6 and the overflow enable in bit 5. Address 2+1=3 (serial enables) holds the tx_empty enable in bit 7, the tx_done enable in bit 6, the shared receive enable in bit 5 and the idle enable in bit 4. Both are written and read back, and their other bits read as zero. Addresses 4..9 read as zero.
- R4: One capture enable covers both capture flags, and one compare enable covers both compare flags. The receive enable covers both rx_over and rx_full. Every other flag has its own enable. A flag raises `irq` only while its enable is set.
- R5: While `irq` is high, `vec_hi_addr` is VEC_BASE plus twice the group number and `vec_lo_addr` is one more than that. The groups are wake-up 0, serial 1, overflow 2, compare 3 and capture 4, which with the default base gives 3FF0, 3FF2, 3FF4, 3FF6 and 3FF8. While `irq` is low, both vector outputs are zero.
- R6: When several groups request at once, the lowest group number wins.
- R7: `irq_mask` high blocks the timer and serial groups. `wake_req` high always raises `irq` and selects group 0.
- R8: A status read while a flag is set arms that flag. A later access of its data register then clears it at that edge. Capture A uses address 4, capture B address 5, compare A address 6, compare B address 7 and overflow address 8; on these, either a read or a write counts.
- R9: A data-register access on a flag that is not armed leaves the flag set. Accessing another register between the two steps leaves the arm in place.
- R10: A set pulse on an armed flag disarms it. The next data access then leaves it set, and a fresh status read re-arms it.
- R11: On serial data address 9, a write clears the armed tx_empty and tx_done flags only. A read clears the armed rx_over, rx_full and line_idle flags only.
- R12: A set pulse in the same cycle as a clearing access leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_set | input | 5 | Timer set pulses {cap_a, cap_b, cmp_a, cmp_b, ovf} |
| ser_set | input | 5 | Serial set pulses {tx_empty, tx_done, rx_over, rx_full, line_idle} |
| wake_req | input | 1 | Nonmaskable wake-up request (level) |
| irq_mask | input | 1 | Global mask for timer and serial groups |
| reg_addr | input | 4 | Register address |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from address) |
| irq | output | 1 | Interrupt request |
| vec_hi_addr | output | 16 | Address of the handler-address high byte |
| vec_lo_addr | output | 16 | Address of the handler-address low byte |

## Verification
Flags, arms and enables change at the rising edge that follows a set pulse, a strobe or a write. Read data, `irq` and the vector outputs are combinational from that state and from `irq_mask` and `wake_req`. The bench therefore drives all inputs at the falling edge and samples results at the next falling edge, one cycle after a register-affecting stimulus. It samples read data and outputs that depend only on the mask or wake-up inputs 1 ns after driving, within the same cycle.

// File: rtl/pirqv_pkg.sv
package pirqv_pkg;

    localparam int DW      = 8;
    localparam int AW      = 4;
    localparam int NT      = 5;
    localparam int NS      = 5;
    localparam int NG      = 5;
    localparam int GW      = $clog2(NG);
    localparam int VW      = 16;

    // register addresses
    typedef enum logic [AW-1:0] {
        A_TSTAT = 4'd0,
        A_TCTRL = 4'd1,
        A_SSTAT = 4'd2,
        A_SCTRL = 4'd3,
        A_CAPA  = 4'd4,
        A_CAPB  = 4'd5,
        A_CMPA  = 4'd6,
        A_CMPB  = 4'd7,
        A_TCNT  = 4'd8,
        A_SDATA = 4'd9
    } reg_addr_e;

    // vector groups, lowest number has highest priority
    typedef enum logic [GW-1:0] {
        G_WAKE = 3'd0,
        G_SER  = 3'd1,
        G_OVF  = 3'd2,
        G_CMP  = 3'd3,
        G_CAP  = 3'd4
    } grp_e;

    // timer flag indices (status bit = index + 3)
    localparam int F_OVF  = 0;
    localparam int F_CMPB = 1;
    localparam int F_CMPA = 2;
    localparam int F_CAPB = 3;
    localparam int F_CAPA = 4;

    // serial flag indices
    localparam int S_IDL = 0;
    localparam int S_RXF = 1;
    localparam int S_ORV = 2;
    localparam int S_TXC = 3;
    localparam int S_TXE = 4;

    typedef struct packed {
        logic cap;
        logic cmp;
        logic ovf;
    } tmr_en_t;

    typedef struct packed {
        logic txe;
        logic txc;
        logic rx;
        logic idl;
    } ser_en_t;

    typedef struct packed {
        logic hit;
        logic [GW-1:0] grp;
    } pick_t;

    function automatic logic [VW-1:0] vec_of(input logic [VW-1:0] base,
                                             input logic [GW-1:0] g);
        return base + VW'({g, 1'b0});
    endfunction

endpackage

// File: rtl/pirqv_flag_cell.sv
module pirqv_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_p,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (set_p) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (clr_acc && armed) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (stat_rd) begin
            armed <= flag;
        end
    end
endmodule

// File: rtl/pirqv_regs.sv
module pirqv_regs
    import pirqv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [NT-1:0] tflags,
    input  logic [NS-1:0] sflags,
    output logic [DW-1:0] rdata,
    output tmr_en_t       ten,
    output ser_en_t       sen,
    output logic          tstat_rd,
    output logic          sstat_rd,
    output logic [NT-1:0] tclr,
    output logic [NS-1:0] sclr
);
    localparam int TPAD = DW - NT;
    localparam int TEW  = $bits(tmr_en_t);
    localparam int SEW  = $bits(ser_en_t);

    logic acc;
    logic unused_wbits;

    assign acc          = rd | wr;
    assign unused_wbits = ^wdata[DW-SEW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ten <= '0;
            sen <= '0;
        end else if (wr) begin
            if (addr == A_TCTRL) ten <= tmr_en_t'(wdata[DW-1 -: TEW]);
            if (addr == A_SCTRL) sen <= ser_en_t'(wdata[DW-1 -: SEW]);
        end
    end

    always_comb begin
        case (addr)
            A_TSTAT: rdata = {tflags, {TPAD{1'b0}}};
            A_TCTRL: rdata = {ten, {(DW-TEW){1'b0}}};
            A_SSTAT: rdata = {sflags, {(DW-NS){1'b0}}};
            A_SCTRL: rdata = {sen, {(DW-SEW){1'b0}}};
            default: rdata = '0;
        endcase
    end

    assign tstat_rd = rd && (addr == A_TSTAT);
    assign sstat_rd = rd && (addr == A_SSTAT);

    always_comb begin
        tclr         = '0;
        tclr[F_CAPA] = acc && (addr == A_CAPA);
        tclr[F_CAPB] = acc && (addr == A_CAPB);
        tclr[F_CMPA] = acc && (addr == A_CMPA);
        tclr[F_CMPB] = acc && (addr == A_CMPB);
        tclr[F_OVF]  = acc && (addr == A_TCNT);
    end

    always_comb begin
        sclr        = '0;
        sclr[S_TXE] = wr && (addr == A_SDATA);
        sclr[S_TXC] = wr && (addr == A_SDATA);
        sclr[S_ORV] = rd && (addr == A_SDATA);
        sclr[S_RXF] = rd && (addr == A_SDATA);
        sclr[S_IDL] = rd && (addr == A_SDATA);
    end
endmodule

// File: rtl/pirqv_pick.sv
module pirqv_pick #(
    parameter int N = 5,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         hit,
    output logic [W-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/periph_irq_vector.sv
module periph_irq_vector
    import pirqv_pkg::*;
#(
    parameter logic [15:0] VEC_BASE = 16'h3FF0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    tmr_set,
    input  logic [4:0]    ser_set,
    input  logic          wake_req,
    input  logic          irq_mask,
    input  logic [3:0]    reg_addr,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic [15:0]   vec_hi_addr,
    output logic [15:0]   vec_lo_addr
);
    logic [NT-1:0] tflags, tarms, tclr;
    logic [NS-1:0] sflags, sarms, sclr;
    logic          tstat_rd, sstat_rd;
    tmr_en_t       ten;
    ser_en_t       sen;
    logic [NG-1:0] req;
    pick_t         pick;
    logic [NT+NS-1:0] all_flags, all_arms;

    pirqv_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .tflags   (tflags),
        .sflags   (sflags),
        .rdata    (reg_rdata),
        .ten      (ten),
        .sen      (sen),
        .tstat_rd (tstat_rd),
        .sstat_rd (sstat_rd),
        .tclr     (tclr),
        .sclr     (sclr)
    );

    for (genvar i = 0; i < NT; i++) begin : g_tcell
        pirqv_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_p   (tmr_set[i]),
            .stat_rd (tstat_rd),
            .clr_acc (tclr[i]),
            .flag    (tflags[i]),
            .armed   (tarms[i])
        );
    end

    for (genvar i = 0; i < NS; i++) begin : g_scell
        pirqv_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_p   (ser_set[i]),
            .stat_rd (sstat_rd),
            .clr_acc (sclr[i]),
            .flag    (sflags[i]),
            .armed   (sarms[i])
        );
    end

    assign all_flags = {tflags, sflags};
    assign all_arms  = {tarms, sarms};

    // group requests, shared enables folded here
    always_comb begin
        req         = '0;
        req[G_WAKE] = wake_req;
        req[G_SER]  = !irq_mask && ((sflags[S_TXE] && sen.txe) ||
                                    (sflags[S_TXC] && sen.txc) ||
                                    ((sflags[S_ORV] || sflags[S_RXF]) && sen.rx) ||
                                    (sflags[S_IDL] && sen.idl));
        req[G_OVF]  = !irq_mask && tflags[F_OVF] && ten.ovf;
        req[G_CMP]  = !irq_mask && (tflags[F_CMPA] || tflags[F_CMPB]) && ten.cmp;
        req[G_CAP]  = !irq_mask && (tflags[F_CAPA] || tflags[F_CAPB]) && ten.cap;
    end

    pirqv_pick #(.N(NG)) u_pick (
        .req (req),
        .hit (pick.hit),
        .idx (pick.grp)
    );

    assign irq         = pick.hit;
    assign vec_hi_addr = pick.hit ? vec_of(VEC_BASE, pick.grp) : '0;
    assign vec_lo_addr = pick.hit ? vec_of(VEC_BASE, pick.grp) + 16'd1 : '0;
endmodule

// File: rtl/pirqv_chk.sv
module pirqv_chk #(
    parameter logic [15:0] BASE = 16'h3FF0
) (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  tmr_set,
    input logic [4:0]  ser_set,
    input logic        wake_req,
    input logic        irq_mask,
    input logic [3:0]  reg_addr,
    input logic [7:0]  reg_rdata,
    input logic        irq,
    input logic [15:0] vec_hi_addr,
    input logic [15:0] vec_lo_addr,
    input logic [9:0]  flags,
    input logic [9:0]  arms
);
    logic [9:0] setv;
    assign setv = {tmr_set, ser_set};

    // R2, R12: a set pulse always lands
    a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((flags & $past(setv)) == $past(setv)));

    // R8, R9: a flag only falls when it was armed
    a_r8_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(flags) & ~flags & ~$past(arms)) == 10'd0));

    // R10: an arm never outlives its flag
    a_r10_arm_only_when_set: assert property (@(posedge clk) disable iff (rst)
        (arms & ~flags) == 10'd0);

    // R7
    a_r7_wake_nonmaskable: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (irq && vec_hi_addr == BASE));

    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (irq_mask && !wake_req) |-> !irq);

    // R5
    a_r5_pair: assert property (@(posedge clk) disable iff (rst)
        irq |-> (vec_lo_addr == vec_hi_addr + 16'd1));

    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (vec_hi_addr == 16'd0 && vec_lo_addr == 16'd0));

    // R3
    a_r3_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 4'd1) |-> (reg_rdata[4:0] == 5'd0));

    // R2
    a_r2_stat_low_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 4'd0 || reg_addr == 4'd2) |-> (reg_rdata[2:0] == 3'd0));
endmodule

bind periph_irq_vector pirqv_chk #(.BASE(VEC_BASE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tmr_set     (tmr_set),
    .ser_set     (ser_set),
    .wake_req    (wake_req),
    .irq_mask    (irq_mask),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .vec_hi_addr (vec_hi_addr),
    .vec_lo_addr (vec_lo_addr),
    .flags       (all_flags),
    .arms        (all_arms)
);

// File: tb/tb_periph_irq_vector.sv
`timescale 1ns/1ps
module tb_periph_irq_vector;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  tmr_set, ser_set;
    logic        wake_req, irq_mask;
    logic [3:0]  reg_addr;
    logic        reg_rd, reg_wr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        irq;
    logic [15:0] vec_hi_addr, vec_lo_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    periph_irq_vector dut (
        .clk(clk), .rst(rst), .tmr_set(tmr_set), .ser_set(ser_set),
        .wake_req(wake_req), .irq_mask(irq_mask), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .vec_hi_addr(vec_hi_addr),
        .vec_lo_addr(vec_lo_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] t, input logic [4:0] s);
        tmr_set = t; ser_set = s;
        @(negedge clk);
        tmr_set = '0; ser_set = '0;
    endtask

    // expected {irq, vec_hi}
    function automatic logic [31:0] expect_out(input logic [4:0] tf, input logic [4:0] sf,
            input logic [2:0] te, input logic [3:0] se, input logic m, input logic w);
        logic cap, cmp, ovf, ser;
        cap = (tf[4] | tf[3]) & te[2];
        cmp = (tf[2] | tf[1]) & te[1];
        ovf = tf[0] & te[0];
        ser = (sf[4] & se[3]) | (sf[3] & se[2]) | ((sf[2] | sf[1]) & se[1]) | (sf[0] & se[0]);
        if (w)        return {15'd0, 1'b1, 16'h3FF0};
        else if (m)   return 32'd0;
        else if (ser) return {15'd0, 1'b1, 16'h3FF2};
        else if (ovf) return {15'd0, 1'b1, 16'h3FF4};
        else if (cmp) return {15'd0, 1'b1, 16'h3FF6};
        else if (cap) return {15'd0, 1'b1, 16'h3FF8};
        else          return 32'd0;
    endfunction

    function automatic logic [31:0] obs();
        return {15'd0, irq, vec_hi_addr};
    endfunction

    initial begin
        logic [7:0] d;
        rst = 1'b1; tmr_set = '0; ser_set = '0; wake_req = 1'b0; irq_mask = 1'b0;
        reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(4'd0, d); chk("R1 tstat", {24'd0, d}, 32'd0);
        rd(4'd1, d); chk("R1 tctrl", {24'd0, d}, 32'd0);
        rd(4'd2, d); chk("R1 sstat", {24'd0, d}, 32'd0);
        rd(4'd3, d); chk("R1 sctrl", {24'd0, d}, 32'd0);
        chk("R1 irq/vec", obs(), 32'd0);
        chk("R1 vec_lo", {16'd0, vec_lo_addr}, 32'd0);

        // R3 enable layout, unused bits, data addresses read zero
        wr(4'd1, 8'hFF); rd(4'd1, d); chk("R3 tctrl", {24'd0, d}, 32'hE0);
        wr(4'd3, 8'hFF); rd(4'd3, d); chk("R3 sctrl", {24'd0, d}, 32'hF0);
        for (int a = 4; a <= 9; a++) begin
            rd(4'(a), d); chk("R3 data addr", {24'd0, d}, 32'd0);
        end

        // R2 R4 R5 R6 timer sweep
        for (int p = 0; p < 32; p++) begin
            do_reset();
            pulse(5'(p), 5'd0);
            rd(4'd0, d); chk("R2 tstat", {24'd0, d}, {24'd0, 5'(p), 3'd0});
            for (int e = 0; e < 8; e++) begin
                wr(4'd1, {3'(e), 5'd0});
                chk("R4/R6 timer", obs(), expect_out(5'(p), 5'd0, 3'(e), 4'd0, 1'b0, 1'b0));
                if (irq) chk("R5 pair", {16'd0, vec_lo_addr}, {16'd0, vec_hi_addr + 16'd1});
            end
        end

        // R2 R4 serial sweep
        for (int p = 0; p < 32; p++) begin
            do_reset();
            pulse(5'd0, 5'(p));
            rd(4'd2, d); chk("R2 sstat", {24'd0, d}, {24'd0, 5'(p), 3'd0});
            for (int e = 0; e < 16; e++) begin
                wr(4'd3, {4'(e), 4'd0});
                chk("R4 serial", obs(), expect_out(5'd0, 5'(p), 3'd0, 4'(e), 1'b0, 1'b0));
            end
        end

        // R6 R7 mixed groups with mask and wake
        for (int c = 0; c < 16; c++) begin
            logic [4:0] tf, sf;
            tf = {c[2], 1'b0, c[1], 1'b0, c[0]};
            sf = {3'd0, c[3], 1'b0};
            do_reset();
            wr(4'd1, 8'hE0); wr(4'd3, 8'hF0);
            pulse(tf, sf);
            for (int m = 0; m < 2; m++) begin
                for (int w = 0; w < 2; w++) begin
                    irq_mask = m[0]; wake_req = w[0];
                    #1;
                    chk("R6/R7 prio", obs(), expect_out(tf, sf, 3'b111, 4'hF, m[0], w[0]));
                end
            end
            irq_mask = 1'b0; wake_req = 1'b0;
            @(negedge clk);
        end

        // R8 two-step clear
        do_reset();
        wr(4'd1, 8'hE0);
        pulse(5'b10000, 5'd0);
        rd(4'd0, d);
        wr(4'd4, 8'h00);
        rd(4'd0, d); chk("R8 cap_a cleared", {24'd0, d}, 32'd0);
        chk("R8 irq drops", obs(), 32'd0);

        // R9 no arm no clear; arm survives unrelated access
        do_reset();
        pulse(5'b00100, 5'd0);
        rd(4'd6, d);
        rd(4'd0, d); chk("R9 unarmed stays", {24'd0, d}, 32'h20);
        rd(4'd7, d);
        wr(4'd6, 8'h00);
        rd(4'd0, d); chk("R9 arm kept", {24'd0, d}, 32'd0);

        // R10 set between read and access
        do_reset();
        pulse(5'b00001, 5'd0);
        rd(4'd0, d);
        pulse(5'b00001, 5'd0);
        rd(4'd8, d);
        wr(4'd8, 8'h00);
        rd(4'd0, d); chk("R10 resets survive", {24'd0, d}, 32'h08);
        rd(4'd8, d);
        rd(4'd0, d); chk("R10 rearm clears", {24'd0, d}, 32'd0);

        // R11 serial read/write split
        do_reset();
        pulse(5'd0, 5'b11111);
        rd(4'd2, d);
        wr(4'd9, 8'h55);
        rd(4'd2, d); chk("R11 write clears tx", {24'd0, d}, 32'h38);
        rd(4'd9, d); chk("R11 data reads zero", {24'd0, d}, 32'd0);
        rd(4'd2, d); chk("R11 read clears rx", {24'd0, d}, 32'd0);

        // R12 set beats clear
        do_reset();
        pulse(5'b01000, 5'd0);
        rd(4'd0, d);
        reg_addr = 4'd5; reg_rd = 1'b1; tmr_set = 5'b01000;
        @(negedge clk);
        reg_rd = 1'b0; tmr_set = '0;
        rd(4'd0, d); chk("R12 set wins", {24'd0, d}, 32'h40);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule